// File: doc/BRIEF.md
# External Interrupt Sense Controller

This block watches a set of external interrupt pins and turns their activity into a single interrupt request for a processor. Each pin first passes through a two-flop synchroniser. Each line is then set up for one of four senses: low level, high level, rising edge or falling edge. Three separate bit-per-line configuration registers make that choice. A detected condition sets a per-line status bit. That bit only reaches the processor when the line's mask bit is also set. The combined request is the registered OR of every status bit whose mask bit is set.

Software reaches the block through a plain synchronous register port. It has a write strobe, a read strobe, a word address and 32-bit data. Read data is registered and appears one cycle after the read strobe. The mask is changed through a pair of write-one-to-set and write-one-to-clear addresses and is read back at a third address. Only the low `NUM_LINES` bit positions are implemented. All other positions read as zero, so software can write all ones to the sense-kind register and count the ones it reads back to learn the line count.

Top module: `ext_irq_sense_ctrl`

## Requirements
- R1: After reset, every readable register returns 0, `rd_data` is 0 and `irq_req` is low. The readable registers are sense-kind (address 0), edge-direction (1), level-polarity (2), mask (5) and status (6).
- R2: A line whose sense-kind bit (address 0) is 1 is level-sensitive. Its status bit follows the synchronised pin. The line is active when the pin equals its level-polarity bit (address 2): 1 means active-high, 0 means active-low.
- R3: A line whose sense-kind bit is 0 is edge-sensitive. Its edge-direction bit (address 1) selects a rising edge when 1 and a falling edge when 0. With every configuration register at its reset value of 0, every line detects falling edges only.
- R4: The status bit (read at address 6) of an edge-sensitive line stays set until software writes a 1 to that bit position at address 7. Zero bits written at address 7 leave status unchanged.
- R5: Writing a 1 at address 3 sets that line's mask bit. Writing a 1 at address 4 clears it. Zero bits at either address change nothing. Address 5 reads back the current mask.
- R6: `irq_req` is the OR over all lines of status AND mask, registered for one cycle. A masked-off line still sets its status bit, but that bit does not raise `irq_req`.
- R7: Bit positions at or above `NUM_LINES` read as 0 in every register. Writing all ones at address 0 reads back with exactly `NUM_LINES` low ones.
- R8: When an edge is detected on a line in the same cycle that software writes a 1 for that line at address 7, the status bit ends up set.
- R9: For a level-sensitive line, writing its bit at address 7 while the level is active leaves its status set.
- R10: A pin change reaches the status bit on the third rising clock edge after it becomes stable (two synchroniser stages plus the status flop). `irq_req` follows one edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pins_in | input | NUM_LINES | Asynchronous external interrupt pins |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Register word address |
| bus_wdata | input | DATA_W | Write data |
| rd_data | output | DATA_W | Registered read data, valid the cycle after `bus_rd` |
| irq_req | output | 1 | Combined interrupt request to the processor |

## Verification
The assertions assume that `bus_wr` and `bus_rd` are never raised in the same cycle. They also assume that reset is held from time zero through at least one clock edge, so that the sampled history starts clean. The bench issues every register access as a single-cycle strobe that is dropped before the next one. It keeps the pins low while reset is asserted, so the synchroniser's reset value never looks like a pin edge. Pin changes are driven between clock edges and held for several cycles. The one exception is the set-versus-clear case, where the clear write is placed deliberately on the edge that detects the pin transition.

// File: rtl/eisc_pkg.sv
package eisc_pkg;
  // Register word addresses
  localparam int unsigned ADDR_KIND     = 0; // 1 = level, 0 = edge
  localparam int unsigned ADDR_EDGE_DIR = 1; // 1 = rising, 0 = falling
  localparam int unsigned ADDR_LVL_POL  = 2; // 1 = active-high, 0 = active-low
  localparam int unsigned ADDR_MASK_SET = 3; // write-one-to-set
  localparam int unsigned ADDR_MASK_CLR = 4; // write-one-to-clear
  localparam int unsigned ADDR_MASK_VAL = 5; // read-only mask
  localparam int unsigned ADDR_STATUS   = 6; // read-only latched status
  localparam int unsigned ADDR_ACK      = 7; // write-one-to-clear status
endpackage

// File: rtl/eisc_sync.sv
module eisc_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] pipe [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < STAGES; k++) pipe[k] <= '0;
    end else begin
      pipe[0] <= d;
      for (int k = 1; k < STAGES; k++) pipe[k] <= pipe[k-1];
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/eisc_line.sv
module eisc_line (
  input  logic clk,
  input  logic rst,
  input  logic pin_s,    // synchronised pin
  input  logic is_level, // 1 = level sense
  input  logic rise_sel, // edge mode: 1 = rising
  input  logic high_sel, // level mode: 1 = active-high
  input  logic ack,      // software clear for this line
  output logic stat
);
  logic pin_d;
  logic edge_hit;
  logic lvl_on;

  assign edge_hit = rise_sel ? (pin_s & ~pin_d) : (~pin_s & pin_d);
  assign lvl_on   = (pin_s == high_sel);

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_d <= 1'b0;
      stat  <= 1'b0;
    end else begin
      pin_d <= pin_s;
      if (is_level) stat <= lvl_on;
      else          stat <= edge_hit | (stat & ~ack); // detection beats clear
    end
  end
endmodule

// File: rtl/eisc_regs.sv
module eisc_regs #(
  parameter int N  = 8,
  parameter int AW = 4,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  input  logic [N-1:0]  status,
  output logic [N-1:0]  kind,
  output logic [N-1:0]  rise,
  output logic [N-1:0]  high,
  output logic [N-1:0]  mask,
  output logic [N-1:0]  ack,
  output logic [DW-1:0] rd_data
);
  import eisc_pkg::*;

  localparam logic [DW-1:0] IMPL = (N >= DW) ? {DW{1'b1}} : ((DW'(1) << N) - DW'(1));
  localparam logic [AW-1:0] A_KIND = AW'(ADDR_KIND);
  localparam logic [AW-1:0] A_DIR  = AW'(ADDR_EDGE_DIR);
  localparam logic [AW-1:0] A_POL  = AW'(ADDR_LVL_POL);
  localparam logic [AW-1:0] A_SET  = AW'(ADDR_MASK_SET);
  localparam logic [AW-1:0] A_CLR  = AW'(ADDR_MASK_CLR);
  localparam logic [AW-1:0] A_MSK  = AW'(ADDR_MASK_VAL);
  localparam logic [AW-1:0] A_STS  = AW'(ADDR_STATUS);
  localparam logic [AW-1:0] A_ACK  = AW'(ADDR_ACK);

  logic [DW-1:0] kind_q, rise_q, high_q, mask_q;
  logic [DW-1:0] wmasked, status_w, ack_w, rd_next;

  assign wmasked  = bus_wdata & IMPL;
  assign ack_w    = (bus_wr && bus_addr == A_ACK) ? wmasked : '0;
  assign status_w = DW'(status);

  always_ff @(posedge clk) begin
    if (rst) begin
      kind_q <= '0;
      rise_q <= '0;
      high_q <= '0;
      mask_q <= '0;
    end else if (bus_wr) begin
      case (bus_addr)
        A_KIND:  kind_q <= wmasked;
        A_DIR:   rise_q <= wmasked;
        A_POL:   high_q <= wmasked;
        A_SET:   mask_q <= mask_q | wmasked;
        A_CLR:   mask_q <= mask_q & ~wmasked;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (bus_addr)
      A_KIND:  rd_next = kind_q;
      A_DIR:   rd_next = rise_q;
      A_POL:   rd_next = high_q;
      A_MSK:   rd_next = mask_q;
      A_STS:   rd_next = status_w;
      default: rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         rd_data <= '0;
    else if (bus_rd) rd_data <= rd_next;
  end

  assign kind = kind_q[N-1:0];
  assign rise = rise_q[N-1:0];
  assign high = high_q[N-1:0];
  assign mask = mask_q[N-1:0];
  assign ack  = ack_w[N-1:0];
endmodule

// File: rtl/ext_irq_sense_ctrl.sv
module ext_irq_sense_ctrl #(
  parameter int NUM_LINES   = 8,
  parameter int ADDR_W      = 4,
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LINES-1:0] pins_in,
  input  logic                 bus_wr,
  input  logic                 bus_rd,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [DATA_W-1:0]    bus_wdata,
  output logic [DATA_W-1:0]    rd_data,
  output logic                 irq_req
);
  logic [NUM_LINES-1:0] pins_s;
  logic [NUM_LINES-1:0] status_vec, kind_vec, rise_vec, high_vec, mask_vec, ack_vec;

  eisc_sync #(.W(NUM_LINES), .STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst(rst), .d(pins_in), .q(pins_s)
  );

  eisc_regs #(.N(NUM_LINES), .AW(ADDR_W), .DW(DATA_W)) regs_i (
    .clk(clk), .rst(rst),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .status(status_vec),
    .kind(kind_vec), .rise(rise_vec), .high(high_vec), .mask(mask_vec), .ack(ack_vec),
    .rd_data(rd_data)
  );

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    eisc_line line_i (
      .clk(clk), .rst(rst),
      .pin_s(pins_s[i]),
      .is_level(kind_vec[i]),
      .rise_sel(rise_vec[i]),
      .high_sel(high_vec[i]),
      .ack(ack_vec[i]),
      .stat(status_vec[i])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) irq_req <= 1'b0;
    else     irq_req <= |(status_vec & mask_vec);
  end
endmodule

// File: rtl/eisc_chk.sv
module eisc_chk #(
  parameter int N  = 8,
  parameter int AW = 4,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          bus_wr,
  input logic          bus_rd,
  input logic [AW-1:0] bus_addr,
  input logic [DW-1:0] bus_wdata,
  input logic [DW-1:0] rd_data,
  input logic          irq_req,
  input logic [N-1:0]  status,
  input logic [N-1:0]  mask,
  input logic [N-1:0]  kind
);
  import eisc_pkg::*;

  logic [N-1:0] ackv, hold;
  assign ackv = (bus_wr && bus_addr == AW'(ADDR_ACK)) ? bus_wdata[N-1:0] : '0;
  assign hold = status & ~kind & ~ackv;

  // R6
  irq_follows_pending_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq_req == $past(|(status & mask))));

  // R5
  mask_set_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == AW'(ADDR_MASK_SET)) |=>
      ((mask & $past(bus_wdata[N-1:0])) == $past(bus_wdata[N-1:0])));

  // R5
  mask_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == AW'(ADDR_MASK_CLR)) |=>
      ((mask & $past(bus_wdata[N-1:0])) == '0));

  // R4
  edge_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((status & $past(hold)) == $past(hold)));

  if (N < DW) begin : g_hi
    // R7
    unimpl_zero_chk: assert property (@(posedge clk) disable iff (rst)
      bus_rd |=> (rd_data[DW-1:N] == '0));
  end else begin : g_full
    // R7
    unimpl_zero_chk: assert property (@(posedge clk) disable iff (rst)
      bus_rd |=> (rd_data == rd_data));
  end
endmodule

bind ext_irq_sense_ctrl eisc_chk #(.N(NUM_LINES), .AW(ADDR_W), .DW(DATA_W)) chk_i (
  .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .rd_data(rd_data), .irq_req(irq_req),
  .status(status_vec), .mask(mask_vec), .kind(kind_vec)
);

// File: tb/ext_irq_sense_ctrl_tb_top.sv
module ext_irq_sense_ctrl_tb_top;
  localparam int N  = 8;
  localparam int AW = 4;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [N-1:0]  pins = '0;
  logic          wr = 1'b0, rd = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  wire  [DW-1:0] rdata;
  wire           irq;

  always #4 clk = ~clk; // 125 MHz

  ext_irq_sense_ctrl #(.NUM_LINES(N), .ADDR_W(AW), .DATA_W(DW)) dut_i (
    .clk(clk), .rst(rst), .pins_in(pins), .bus_wr(wr), .bus_rd(rd),
    .bus_addr(addr), .bus_wdata(wdata), .rd_data(rdata), .irq_req(irq)
  );

  int checks = 0, fails = 0;
  bit cmp_on = 0;

  task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // behavioural reference for the interrupt request
  logic [N-1:0] m_q1, m_q2, m_old, m_st, m_kind, m_rise, m_high, m_mask, m_ack, m_nx;
  logic         m_irq;
  always @(posedge clk) begin
    if (rst) begin
      m_q1 = '0; m_q2 = '0; m_old = '0; m_st = '0;
      m_kind = '0; m_rise = '0; m_high = '0; m_mask = '0; m_irq = 0;
    end else begin
      m_ack = (wr && addr == 4'd7) ? wdata[N-1:0] : '0;
      for (int i = 0; i < N; i++) begin
        if (m_kind[i]) m_nx[i] = (m_q2[i] == m_high[i]);
        else if ((m_rise[i] && m_q2[i] && !m_old[i]) || (!m_rise[i] && !m_q2[i] && m_old[i]))
          m_nx[i] = 1'b1;
        else m_nx[i] = m_st[i] && !m_ack[i];
      end
      m_irq = |(m_st & m_mask);
      m_old = m_q2; m_q2 = m_q1; m_q1 = pins; m_st = m_nx;
      if (wr) begin
        case (addr)
          4'd0: m_kind = wdata[N-1:0];
          4'd1: m_rise = wdata[N-1:0];
          4'd2: m_high = wdata[N-1:0];
          4'd3: m_mask = m_mask | wdata[N-1:0];
          4'd4: m_mask = m_mask & ~wdata[N-1:0];
          default: ;
        endcase
      end
    end
  end

  always @(negedge clk) if (cmp_on) check("R6 irq_req vs reference", DW'(irq), DW'(m_irq));

  task automatic wreg(input int a, input logic [DW-1:0] d);
    @(negedge clk); wr = 1; addr = AW'(a); wdata = d;
    @(negedge clk); wr = 0; wdata = '0;
  endtask

  task automatic rchk(input int a, input logic [DW-1:0] exp, input string tag);
    @(negedge clk); rd = 1; addr = AW'(a);
    @(negedge clk); rd = 0;
    check(tag, rdata, exp);
  endtask

  task automatic settle();
    repeat (5) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    cmp_on = 1;
    // R1 reset state
    check("R1 rd_data after reset", rdata, '0);
    check("R1 irq_req after reset", DW'(irq), '0);
    for (int a = 0; a < 8; a++) rchk(a, '0, "R1 register reset value");

    // R7 implemented-line discovery
    wreg(2, '1); wreg(1, '1); wreg(0, '1);
    rchk(0, 32'h0000_00FF, "R7 sense-kind readback");
    rchk(1, 32'h0000_00FF, "R7 edge-direction readback");
    rchk(2, 32'h0000_00FF, "R7 level-polarity readback");
    wreg(3, '1);
    rchk(5, 32'h0000_00FF, "R7 mask readback");
    wreg(4, '1); wreg(0, '0); wreg(1, '0); wreg(2, '0);
    rchk(6, '0, "R7 status clean");
    rchk(5, '0, "R5 mask cleared");

    // R3 default falling edge, R10 latency
    wreg(3, 32'h01);
    @(negedge clk); pins[0] = 1'b1;
    settle();
    rchk(6, '0, "R3 rising ignored in falling mode");
    @(negedge clk); pins[0] = 1'b0;
    repeat (3) @(negedge clk);
    check("R10 irq still low after 3 edges", DW'(irq), '0);
    @(negedge clk);
    check("R10 irq high after 4 edges", DW'(irq), 32'h1);
    rchk(6, 32'h01, "R3 falling edge latched");

    // R4 sticky status and ack
    settle();
    rchk(6, 32'h01, "R4 status stays set");
    wreg(7, 32'hFFFF_FFFE);
    rchk(6, 32'h01, "R4 zero ack bits ignored");
    wreg(7, 32'h01);
    rchk(6, '0, "R4 ack clears status");
    @(negedge clk);
    check("R6 irq low after ack", DW'(irq), '0);

    // R3 rising, R6 masked line, R5 mask set/clear
    wreg(1, 32'h02);
    @(negedge clk); pins[1] = 1'b1;
    settle();
    rchk(6, 32'h02, "R6 masked line still latches");
    check("R6 masked line keeps irq low", DW'(irq), '0);
    wreg(3, 32'h02);
    rchk(5, 32'h03, "R5 mask set");
    @(negedge clk);
    check("R6 unmasked pending raises irq", DW'(irq), 32'h1);
    wreg(4, 32'h00);
    rchk(5, 32'h03, "R5 zero clear bits ignored");
    wreg(3, 32'h00);
    rchk(5, 32'h03, "R5 zero set bits ignored");
    wreg(4, 32'h02);
    rchk(5, 32'h01, "R5 mask clear");
    @(negedge clk);
    check("R6 irq drops when masked", DW'(irq), '0);
    wreg(7, 32'h02);
    @(negedge clk); pins[1] = 1'b0;
    settle();
    rchk(6, '0, "R3 falling ignored in rising mode");
    wreg(1, 32'h00);

    // R2 level sense, R9 ack while active
    wreg(2, 32'h04); wreg(0, 32'h0C);
    settle();
    rchk(6, 32'h08, "R2 active-low line with pin low");
    @(negedge clk); pins[2] = 1'b1;
    settle();
    rchk(6, 32'h0C, "R2 active-high line with pin high");
    wreg(7, 32'h04);
    rchk(6, 32'h0C, "R9 ack ignored while level active");
    @(negedge clk); pins[2] = 1'b0;
    settle();
    rchk(6, 32'h08, "R2 level status follows pin low");
    @(negedge clk); pins[3] = 1'b1;
    settle();
    rchk(6, '0, "R2 active-low line released");
    wreg(0, 32'h00); wreg(2, 32'h00);
    settle();
    rchk(6, '0, "R2 back to edge mode clean");

    // R8 set beats clear in the same cycle
    @(negedge clk); pins[4] = 1'b1;
    settle();
    @(negedge clk); pins[4] = 1'b0;       // n0
    @(negedge clk);                       // n1
    @(negedge clk); wr = 1; addr = 4'd7; wdata = 32'h10; // n2, sampled with the detecting edge
    @(negedge clk); wr = 0; wdata = '0;
    rchk(6, 32'h10, "R8 detection wins over same-cycle ack");
    wreg(7, 32'h10);
    rchk(6, '0, "R4 later ack clears");

    settle();
    finish_run();
  end
endmodule